// File: doc/BRIEF.md
# Add/Subtract Overflow Flag Unit

This block is a purely combinational adder/subtractor of parameterized width W with the flag logic that multiword arithmetic needs. It takes two operands, a one-bit carry-or-borrow input and an operation select. It returns the W-bit result, a signed overflow flag and an unsigned carry/borrow flag. The carry/borrow input may be 0 or 1, so the same unit serves both the lowest word and the final, most significant word of a chained operation.

Subtraction is performed as x plus the inverted y plus an effective carry-in. That carry-in is the inverse of the borrow input. The primary signed overflow flag compares the carry entering the sign bit with the carry leaving it. A second, independent formulation adds the operands after flipping both of their sign bits. It reports overflow when its carry out equals the top bit of its sum. Any disagreement between the two formulations, or any difference between the result and the biased sum, raises a cross-check error output.

Top module: `addsub_ovf_flags`

## Requirements
- R1: `res_o` equals the low W bits of x + y + c when `sub_i`=0, and of x − y − c when `sub_i`=1. Higher bits are discarded.
- R2: When `sub_i`=0, `sovf_o` is 1 exactly when x and y share a sign bit and `res_o[W-1]` differs from it. This holds for c=0 and for c=1.
- R3: When `sub_i`=1, `sovf_o` is 1 exactly when x and y differ in sign bit and `res_o[W-1]` differs from `x_i[W-1]`. This holds for c=0 and for c=1.
- R4: When `sub_i`=0, `uflag_o` is bit W of the unsigned sum x + y + c (the carry out).
- R5: When `sub_i`=1, `uflag_o` is the borrow out. It is 1 exactly when unsigned x < y + c, which is the inverse of the carry out of x + ~y + (1 − c).
- R6: When `sub_i`=0 and c=0, `uflag_o` is 1 exactly when `res_o` is unsigned-less-than x or unsigned-less-than y.
- R7: `xchk_err_o` is 0 for every input. The sign-carry overflow and the biased-operand overflow agree, and the biased sum equals `res_o`.
- R8: The outputs depend only on the present inputs, with no storage. With all inputs at zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | W | First operand (minuend for subtract) |
| y_i | input | W | Second operand (subtrahend for subtract) |
| cin_i | input | 1 | Carry-in for add, borrow-in for subtract |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| res_o | output | W | Low W bits of the result |
| sovf_o | output | 1 | Signed overflow |
| uflag_o | output | 1 | Unsigned carry out (add) or borrow out (subtract) |
| xchk_err_o | output | 1 | The two signed-overflow formulations disagree |

## Verification
Every output is due zero cycles after its stimulus, because the block holds no registers. The bench applies each input set on a falling clock edge and reads all outputs a quarter period later, after the logic has settled and away from any edge. A wide signed and unsigned integer model in the bench computes the expected result and flags for each input set. Both the vector table and the sweep follow this same drive-then-sample rhythm.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } arith_op_e;
endpackage

// File: rtl/ovf_sign_carry.sv
// W-bit adder that exposes the carry entering and leaving the sign position.
module ovf_sign_carry #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_in_o,
  output logic         c_out_o
);
  localparam int LW = W - 1;

  function automatic logic [LW:0] low_add(input logic [LW-1:0] a,
                                          input logic [LW-1:0] b,
                                          input logic c);
    return {1'b0, a} + {1'b0, b} + {{LW{1'b0}}, c};
  endfunction

  logic [LW:0] low_sum;
  logic        a_msb, b_msb;

  assign low_sum    = low_add(a_i[LW-1:0], b_i[LW-1:0], cin_i);
  assign c_msb_in_o = low_sum[LW];
  assign a_msb      = a_i[W-1];
  assign b_msb      = b_i[W-1];
  assign sum_o      = {a_msb ^ b_msb ^ c_msb_in_o, low_sum[LW-1:0]};
  assign c_out_o    = (a_msb & b_msb) | (a_msb & c_msb_in_o) | (b_msb & c_msb_in_o);
endmodule

// File: rtl/ovf_biased_check.sv
// Second signed-overflow formulation: flip both sign bits, add or subtract,
// and report overflow when the carry out equals the top sum bit.
module ovf_biased_check
  import ovf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  arith_op_e    op_i,
  input  logic         cin_eff_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W:0] wide_add(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  logic [W-1:0] xb, yb, yb_op;
  logic [W:0]   full;

  assign xb    = x_i ^ MSB_MASK;
  assign yb    = y_i ^ MSB_MASK;
  assign yb_op = (op_i == OP_SUB) ? ~yb : yb;
  assign full  = wide_add(xb, yb_op, cin_eff_i);
  assign sum_o = full[W-1:0];
  assign ovf_o = (full[W] == full[W-1]);
endmodule

// File: rtl/addsub_ovf_flags.sv
module addsub_ovf_flags
  import ovf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         sovf_o,
  output logic         uflag_o,
  output logic         xchk_err_o
);
  arith_op_e    op;
  logic [W-1:0] y_eff;
  logic         cin_eff;
  logic         c_msb_in, c_out;
  logic         sovf_alt;
  logic [W-1:0] alt_sum;

  assign op      = arith_op_e'(sub_i);
  assign y_eff   = (op == OP_SUB) ? ~y_i : y_i;
  assign cin_eff = (op == OP_SUB) ? ~cin_i : cin_i;

  ovf_sign_carry #(.W(W)) u_core (
    .a_i(x_i), .b_i(y_eff), .cin_i(cin_eff),
    .sum_o(res_o), .c_msb_in_o(c_msb_in), .c_out_o(c_out)
  );

  ovf_biased_check #(.W(W)) u_alt (
    .x_i(x_i), .y_i(y_i), .op_i(op), .cin_eff_i(cin_eff),
    .sum_o(alt_sum), .ovf_o(sovf_alt)
  );

  assign sovf_o     = c_msb_in ^ c_out;
  assign uflag_o    = (op == OP_SUB) ? ~c_out : c_out;
  assign xchk_err_o = (sovf_o != sovf_alt) || (alt_sum != res_o);

  always_comb begin
    // R7: both overflow formulations agree
    assert_ovf_agree_R7: assert (sovf_o == sovf_alt);
    // R7 / R1: biased sum equals the result
    assert_biased_sum_R7: assert (alt_sum == res_o);
    if (op == OP_ADD) begin
      // R2: sign rule for add
      assert_add_sign_R2: assert (sovf_o ==
        ((x_i[W-1] == y_i[W-1]) && (res_o[W-1] != x_i[W-1])));
      // R6: unsigned compare rule with no carry-in
      if (!cin_i)
        assert_add_carry_R6: assert (uflag_o == ((res_o < x_i) || (res_o < y_i)));
    end else begin
      // R3: sign rule for subtract
      assert_sub_sign_R3: assert (sovf_o ==
        ((x_i[W-1] != y_i[W-1]) && (res_o[W-1] != x_i[W-1])));
    end
  end
endmodule

// File: tb/test_addsub_ovf_flags.sv
module test_addsub_ovf_flags;
  localparam int W = 8;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] x, y, res;
  logic cin, sub, sovf, uflag, xerr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  addsub_ovf_flags #(.W(W)) i_addsub_ovf_flags (
    .x_i(x), .y_i(y), .cin_i(cin), .sub_i(sub),
    .res_o(res), .sovf_o(sovf), .uflag_o(uflag), .xchk_err_o(xerr)
  );

  // {x, y, c, sub, res, sovf, uflag}
  localparam logic [27:0] TBL [NV] = '{
    {8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0},
    {8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    {8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    {8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0},
    {8'h3F, 8'h40, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0},
    {8'h80, 8'h01, 1'b0, 1'b1, 8'h7F, 1'b1, 1'b0},
    {8'h00, 8'h01, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1},
    {8'h7F, 8'hFF, 1'b0, 1'b1, 8'h80, 1'b1, 1'b1},
    {8'h80, 8'h7F, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0},
    {8'h05, 8'h05, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1},
    {8'h00, 8'h00, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0},
    {8'hC0, 8'hC0, 1'b1, 1'b0, 8'h81, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (x=%0h y=%0h c=%0b sub=%0b)",
               req, act, exp, x, y, cin, sub);
    end
  endtask

  task automatic apply(input logic [W-1:0] xv, input logic [W-1:0] yv,
                       input logic cv, input logic sv);
    @(negedge clk);
    x = xv; y = yv; cin = cv; sub = sv;
    #5;
  endtask

  // Wide reference model
  task automatic check_model();
    longint ux, uy, us, sx, sy, ss;
    logic exp_ovf, exp_u;
    ux = longint'(x); uy = longint'(y);
    sx = longint'($signed(x)); sy = longint'($signed(y));
    if (!sub) begin
      us = ux + uy + cin; ss = sx + sy + cin; exp_u = (us > 255);
    end else begin
      us = ux - uy - cin; ss = sx - sy - cin; exp_u = (us < 0);
    end
    exp_ovf = (ss > 127) || (ss < -128);
    chk("R1 result", longint'(res), us & 64'hFF);
    chk(sub ? "R3 sub signed overflow" : "R2 add signed overflow",
        longint'(sovf), longint'(exp_ovf));
    chk(sub ? "R5 borrow" : "R4 carry", longint'(uflag), longint'(exp_u));
    chk("R7 cross-check", longint'(xerr), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    x = '0; y = '0; cin = 1'b0; sub = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R8: all-zero inputs give all-zero outputs
    apply(8'h00, 8'h00, 1'b0, 1'b0);
    chk("R8 zero result", longint'(res), 0);
    chk("R8 zero flags", longint'({sovf, uflag, xerr}), 0);

    // Vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][27:20], TBL[i][19:12], TBL[i][11], TBL[i][10]);
      chk("R1 table result", longint'(res), longint'(TBL[i][9:2]));
      chk(TBL[i][10] ? "R3 table sovf" : "R2 table sovf",
          longint'(sovf), longint'(TBL[i][1]));
      chk(TBL[i][10] ? "R5 table borrow" : "R4 table carry",
          longint'(uflag), longint'(TBL[i][0]));
      chk("R7 table xchk", longint'(xerr), 0);
    end

    // R6: carry by unsigned compare with c=0
    for (int i = 0; i < 256; i += 17) begin
      apply(8'(i), 8'(255 - i + (i % 3)), 1'b0, 1'b0);
      chk("R6 compare carry", longint'(uflag),
          longint'((res < x) || (res < y)));
    end

    // Strided sweep of all ops and carry values against wide model
    for (int xi = 0; xi < 256; xi += 5)
      for (int yi = 0; yi < 256; yi += 7)
        for (int m = 0; m < 4; m++) begin
          apply(8'(xi), 8'(yi), m[0], m[1]);
          check_model();
        end

    // Extreme corners
    apply(8'h80, 8'hFF, 1'b0, 1'b1); check_model();
    apply(8'h7F, 8'h80, 1'b1, 1'b1); check_model();
    apply(8'hFF, 8'hFF, 1'b1, 1'b0); check_model();
    apply(8'h00, 8'hFF, 1'b1, 1'b1); check_model();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule